// File: doc/BRIEF.md
# Alert-Capturing Status and Control Register

This block is a single 8-bit status/control register reached over a simple internal register bus (device select, word address, write data, write strobe, registered read data). It latches the first fault reported by the monitor comparators. It records which of two channels fired and whether the upper or lower limit was crossed. It then drives an active-low alert output until software acknowledges the fault.

The same register holds two enable controls: auto-monitor and output enable. Each enable is loaded from its own active-low strap pin in the first clock after reset is released, and software can override it afterwards. A write-protect bit powers up set. The block exports a gate that other registers in the device use to refuse writes while protection is on. Writes to this register itself are always accepted, so protection can be lifted.

The register answers only when the device select equals the 4-bit type code 1001, followed by the two address straps and a 0 in the least significant position, and the word address equals 0x0F.

Top module: `alert_status_reg`

## Requirements
- R1: While reset is asserted and after it, until the first pin sample: alertN=1, autoMonitorEn=0, outputEn=0, otherRegWriteAllowed=0 and rdData=0x00.
- R2: On the first clock edge after reset is released, bit 2 (auto-monitor) takes NOT amPinN and bit 1 (output enable) takes NOT enaPinN. Bus writes in that cycle are ignored. Later pin changes have no effect.
- R3: After the pin sample, a write to the register loads bits 2 and 1 from write-data bits 2 and 1, overriding the pin values.
- R4: An alertEvt pulse while bit 3 is 0 sets bit 3. It also stores alertChan in bit 7 and alertLimit in bit 6. The register and the outputs show this after one clock edge.
- R5: alertEvt pulses that arrive while bit 3 is 1 are ignored, so the first fault's channel and limit are kept.
- R6: Writing 0 to bit 3 clears bits 7, 6 and 3. Writing 1 to bit 3 never sets it.
- R7: If a write with bit 3 = 0 and an alertEvt happen in the same cycle, the event is captured with its own channel and limit, and bit 3 stays 1.
- R8: Bit 0 (write protect) resets to 1. Writes to this register load it from write-data bit 0 even while it is 1. otherRegWriteAllowed = NOT bit 0.
- R9: A write or read takes effect only when busSel == {1001, a2Pin, a1Pin, 0} and busAddr == 0x0F. Otherwise the write is ignored and the read returns 0x00.
- R10: rdData shows the selected register value one cycle after the select. Bits 5 and 4 always read 0, and writes to bits 7:4 are ignored.
- R11: alertN = NOT bit 3, autoMonitorEn = bit 2, outputEn = bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| a2Pin | input | 1 | Device address strap, upper |
| a1Pin | input | 1 | Device address strap, lower |
| busSel | input | 7 | Device select from the bus front end |
| busAddr | input | ADDR_W | Word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| amPinN | input | 1 | Active-low auto-monitor strap |
| enaPinN | input | 1 | Active-low output-enable strap |
| alertEvt | input | 1 | One-cycle fault pulse from the comparators |
| alertChan | input | 1 | Channel of the fault |
| alertLimit | input | 1 | 1 = upper limit crossed, 0 = lower |
| alertN | output | 1 | Active-low alert |
| autoMonitorEn | output | 1 | Auto-monitor enable |
| outputEn | output | 1 | Output enable |
| otherRegWriteAllowed | output | 1 | Write gate for the other registers |

## Verification
A corrupted alert latch shows up at alertN one edge after the faulty update, and a read shows it at rdData one cycle later. A lost first fault shows as a changed channel or limit bit after a second pulse. An enable loaded from the wrong source, or at the wrong time, shows at autoMonitorEn/outputEn right after the pin-sample edge, or after a later pin toggle. Decode errors show as a changed register after a foreign write, or as non-zero data from a foreign read, one cycle after the access.

// File: rtl/alert_status_pkg.sv
`timescale 1ns/1ps
package alert_status_pkg;

  localparam int STAT_W   = 8;
  localparam int SEL_W    = 7;
  localparam logic [3:0] DEV_TYPE = 4'b1001;

  localparam int BIT_CHAN  = 7;
  localparam int BIT_LIM   = 6;
  localparam int BIT_ALERT = 3;
  localparam int BIT_AM    = 2;
  localparam int BIT_OE    = 1;
  localparam int BIT_WP    = 0;

  typedef struct packed {
    logic loadPins;
    logic wrCtrl;
    logic clrAlert;
    logic capture;
    logic rdSel;
  } statStrobe_t;

endpackage

// File: rtl/asr_ctrl.sv
`timescale 1ns/1ps
module asr_ctrl
  import alert_status_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 'h0F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 a2Pin,
  input  logic                 a1Pin,
  input  logic [SEL_W-1:0]     busSel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 wrAlertBit,
  input  logic                 alertEvt,
  input  logic                 alertActive,
  output statStrobe_t          strb
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic              pinsPending;
  logic [SEL_W-1:0]  selExpected;
  logic              hit;
  logic              wrHit;

  // Pin sampling occupies the first clock after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinsPending <= 1'b1;
    else       pinsPending <= 1'b0;
  end

  assign selExpected = {DEV_TYPE, a2Pin, a1Pin, 1'b0};
  assign hit         = (busSel == selExpected) && (busAddr == MY_ADDR);
  assign wrHit       = hit && busWrEn && !pinsPending;

  always_comb begin
    strb          = '0;
    strb.loadPins = pinsPending;
    strb.wrCtrl   = wrHit;
    strb.clrAlert = wrHit && !wrAlertBit;
    strb.capture  = alertEvt && (!alertActive || strb.clrAlert);
    strb.rdSel    = hit;
  end

  AST_PIN_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPins |=> !strb.loadPins); // R2

  AST_NO_WRITE_DURING_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && pinsPending |-> !strb.wrCtrl); // R2

endmodule

// File: rtl/asr_datapath.sv
`timescale 1ns/1ps
module asr_datapath
  import alert_status_pkg::*;
#(
  parameter int NUM_EN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  statStrobe_t        strb,
  input  logic [STAT_W-1:0]  wrData,
  input  logic [NUM_EN-1:0]  enPinN,
  input  logic               evtChan,
  input  logic               evtLimit,
  output logic [STAT_W-1:0]  statusValue,
  output logic [STAT_W-1:0]  rdData
);

  logic              chanQ;
  logic              limQ;
  logic              alertQ;
  logic              wpQ;
  logic [NUM_EN-1:0] enQ;
  logic [STAT_W-1:0] rdQ;

  // Enable bits: strap sample first, software override afterwards
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              enQ[g] <= 1'b0;
      else if (strb.loadPins) enQ[g] <= ~enPinN[g];
      else if (strb.wrCtrl)   enQ[g] <= wrData[BIT_OE + g];
    end
  end

  // Alert capture; an event beats a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertQ <= 1'b0;
      chanQ  <= 1'b0;
      limQ   <= 1'b0;
    end else if (strb.capture) begin
      alertQ <= 1'b1;
      chanQ  <= evtChan;
      limQ   <= evtLimit;
    end else if (strb.clrAlert) begin
      alertQ <= 1'b0;
      chanQ  <= 1'b0;
      limQ   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wpQ <= 1'b1;
    else if (strb.wrCtrl) wpQ <= wrData[BIT_WP];
  end

  always_comb begin
    statusValue            = '0;
    statusValue[BIT_CHAN]  = chanQ;
    statusValue[BIT_LIM]   = limQ;
    statusValue[BIT_ALERT] = alertQ;
    statusValue[BIT_OE +: NUM_EN] = enQ;
    statusValue[BIT_WP]    = wpQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= strb.rdSel ? statusValue : '0;
  end

  assign rdData = rdQ;

  AST_ALERT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    alertQ && !strb.clrAlert |=> alertQ && $stable(chanQ) && $stable(limQ)); // R5

  AST_ALERT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertQ) |-> $past(strb.capture)); // R6

  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> alertQ); // R7

  AST_WP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    wpQ && !strb.wrCtrl |=> wpQ); // R8

endmodule

// File: rtl/alert_status_reg.sv
`timescale 1ns/1ps
module alert_status_reg
  import alert_status_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              a2Pin,
  input  logic              a1Pin,
  input  logic [6:0]        busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        rdData,
  input  logic              amPinN,
  input  logic              enaPinN,
  input  logic              alertEvt,
  input  logic              alertChan,
  input  logic              alertLimit,
  output logic              alertN,
  output logic              autoMonitorEn,
  output logic              outputEn,
  output logic              otherRegWriteAllowed
);

  localparam int NUM_EN = BIT_AM - BIT_OE + 1;

  statStrobe_t        strb;
  logic [STAT_W-1:0]  statusValue;
  logic [NUM_EN-1:0]  enPinN;

  assign enPinN = {amPinN, enaPinN};

  asr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .a2Pin       (a2Pin),
    .a1Pin       (a1Pin),
    .busSel      (busSel),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .wrAlertBit  (busWrData[BIT_ALERT]),
    .alertEvt    (alertEvt),
    .alertActive (statusValue[BIT_ALERT]),
    .strb        (strb)
  );

  asr_datapath #(.NUM_EN(NUM_EN)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .enPinN      (enPinN),
    .evtChan     (alertChan),
    .evtLimit    (alertLimit),
    .statusValue (statusValue),
    .rdData      (rdData)
  );

  assign alertN               = ~statusValue[BIT_ALERT];
  assign autoMonitorEn        = statusValue[BIT_AM];
  assign outputEn             = statusValue[BIT_OE];
  assign otherRegWriteAllowed = ~statusValue[BIT_WP];

  AST_EVT_REACHES_PIN: assert property (@(posedge clk) disable iff (!rstN)
    alertEvt |=> !alertN); // R4

endmodule

// File: tb/tb_alert_status_reg.sv
`timescale 1ns/1ps
module tb_alert_status_reg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       a2Pin = 1'b1;
  logic       a1Pin = 1'b0;
  logic [6:0] busSel = '0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] rdData;
  logic       amPinN = 1'b0;
  logic       enaPinN = 1'b1;
  logic       alertEvt = 1'b0;
  logic       alertChan = 1'b0;
  logic       alertLimit = 1'b0;
  logic       alertN, autoMonitorEn, outputEn, otherRegWriteAllowed;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  localparam logic [6:0] SEL_OK  = 7'b1001_10_0;
  localparam logic [7:0] REG_ADR = 8'h0F;

  always #4 clk = ~clk;

  alert_status_reg dut (
    .clk(clk), .rstN(rstN), .a2Pin(a2Pin), .a1Pin(a1Pin),
    .busSel(busSel), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .rdData(rdData),
    .amPinN(amPinN), .enaPinN(enaPinN),
    .alertEvt(alertEvt), .alertChan(alertChan), .alertLimit(alertLimit),
    .alertN(alertN), .autoMonitorEn(autoMonitorEn), .outputEn(outputEn),
    .otherRegWriteAllowed(otherRegWriteAllowed)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [6:0] sel, logic [7:0] adr, logic [7:0] d);
    @(negedge clk);
    busSel = sel; busAddr = adr; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busSel = '0; busAddr = '0; busWrData = '0;
  endtask

  task automatic doRead(logic [6:0] sel, logic [7:0] adr, output logic [7:0] v);
    @(negedge clk);
    busSel = sel; busAddr = adr;
    @(negedge clk);
    v = rdData;
    busSel = '0; busAddr = '0;
  endtask

  task automatic pulseEvt(logic ch, logic lim);
    @(negedge clk);
    alertEvt = 1'b1; alertChan = ch; alertLimit = lim;
    @(negedge clk);
    alertEvt = 1'b0; alertChan = 1'b0; alertLimit = 1'b0;
  endtask

  task automatic outs(string req, logic expAlertN, logic expAm, logic expOe, logic expGate);
    chk(req, {4'b0, alertN, autoMonitorEn, outputEn, otherRegWriteAllowed},
             {4'b0, expAlertN, expAm, expOe, expGate});
  endtask

  task automatic tReset();
    logic [7:0] v;
    repeat (2) @(negedge clk);
    outs("R1 outputs in reset", 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 rdData in reset", rdData, 8'h00);
    rstN = 1'b1;  // released at a negedge; next posedge samples pins
    @(negedge clk);
    outs("R2 straps sampled, R11 mapping", 1'b1, 1'b1, 1'b0, 1'b0);
    doRead(SEL_OK, REG_ADR, v);
    chk("R2 status after strap sample", v, 8'h05);
  endtask

  task automatic tStrapsLater();
    amPinN = 1'b1; enaPinN = 1'b0;
    repeat (3) @(negedge clk);
    outs("R2 later strap change ignored", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tOverride();
    logic [7:0] v;
    doWrite(SEL_OK, REG_ADR, 8'h06);
    outs("R3 override, R8 gate open", 1'b1, 1'b1, 1'b1, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R3 override readback", v, 8'h06);
    doWrite(SEL_OK, REG_ADR, 8'hFE);
    doRead(SEL_OK, REG_ADR, v);
    chk("R10 upper bits ignored, R6 no software raise", v, 8'h06);
    outs("R6 alert not raised by write", 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tCaptureAndKeep();
    logic [7:0] v;
    pulseEvt(1'b1, 1'b0);
    outs("R4 alert asserted, R11", 1'b0, 1'b1, 1'b1, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R4 channel/limit captured", v, 8'h8E);
    pulseEvt(1'b0, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R5 first fault kept", v, 8'h8E);
    doWrite(SEL_OK, REG_ADR, 8'h06);
    outs("R6 alert cleared", 1'b1, 1'b1, 1'b1, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R6 clear readback", v, 8'h06);
    pulseEvt(1'b0, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R4 upper-limit capture", v, 8'h4E);
  endtask

  task automatic tSimultaneous();
    logic [7:0] v;
    // alert active: clear and new event in same cycle
    @(negedge clk);
    busSel = SEL_OK; busAddr = REG_ADR; busWrData = 8'h06; busWrEn = 1'b1;
    alertEvt = 1'b1; alertChan = 1'b1; alertLimit = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busSel = '0; busAddr = '0; busWrData = '0;
    alertEvt = 1'b0; alertChan = 1'b0; alertLimit = 1'b0;
    outs("R7 event wins over clear", 1'b0, 1'b1, 1'b1, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R7 new event stored", v, 8'hCE);
    doWrite(SEL_OK, REG_ADR, 8'h06);
    // alert idle: clear and event in same cycle
    @(negedge clk);
    busSel = SEL_OK; busAddr = REG_ADR; busWrData = 8'h06; busWrEn = 1'b1;
    alertEvt = 1'b1; alertChan = 1'b1; alertLimit = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0; busSel = '0; busAddr = '0; busWrData = '0;
    alertEvt = 1'b0; alertChan = 1'b0;
    doRead(SEL_OK, REG_ADR, v);
    chk("R7 event wins when idle", v, 8'h8E);
    doWrite(SEL_OK, REG_ADR, 8'h06);
  endtask

  task automatic tWriteProtect();
    logic [7:0] v;
    doWrite(SEL_OK, REG_ADR, 8'h07);
    outs("R8 protect set closes gate", 1'b1, 1'b1, 1'b1, 1'b0);
    doWrite(SEL_OK, REG_ADR, 8'h02);
    outs("R8 write accepted while protected", 1'b1, 1'b0, 1'b1, 1'b1);
    doRead(SEL_OK, REG_ADR, v);
    chk("R8 readback", v, 8'h02);
  endtask

  task automatic tDecode();
    logic [7:0] v;
    doWrite(7'b1001_11_0, REG_ADR, 8'h05);
    doWrite(7'b1001_10_1, REG_ADR, 8'h05);
    doWrite(SEL_OK, 8'h0E, 8'h05);
    doWrite(7'b1011_10_0, REG_ADR, 8'h05);
    outs("R9 foreign writes ignored", 1'b1, 1'b0, 1'b1, 1'b1);
    doRead(7'b1001_11_0, REG_ADR, v);
    chk("R9 foreign select reads zero", v, 8'h00);
    doRead(SEL_OK, 8'h0E, v);
    chk("R9 foreign address reads zero", v, 8'h00);
    a1Pin = 1'b1;
    doWrite(7'b1001_11_0, REG_ADR, 8'h04);
    doRead(7'b1001_11_0, REG_ADR, v);
    chk("R9 strap-moved select accepted", v, 8'h04);
    a1Pin = 1'b0;
  endtask

  task automatic tLatency();
    @(negedge clk);
    busSel = SEL_OK; busAddr = REG_ADR;
    #1;
    chk("R10 no data before one cycle", rdData, 8'h00);
    @(negedge clk);
    chk("R10 data after one cycle", rdData, 8'h04);
    busSel = '0; busAddr = '0;
    @(negedge clk);
    chk("R10 data drops after deselect", rdData, 8'h00);
  endtask

  initial begin
    tReset();
    tStrapsLater();
    tOverride();
    tCaptureAndKeep();
    tSimultaneous();
    tWriteProtect();
    tDecode();
    tLatency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule